// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block watches the first six bytes of every received Ethernet frame, the destination address, and gives one accept-or-reject verdict per frame. Bytes arrive one per clock on a byte-wide bus. A byte counts only in a cycle where the byte-valid strobe is high, and a start-of-frame strobe marks the first byte. A receive path uses the verdict to keep or drop the rest of the frame.

Five rules decide the verdict. A promiscuous control accepts everything. A broadcast policy accepts or rejects the all-ones address. A unicast address is accepted on an exact match with the station address, or when its bit is set in an individual-address hash table. A group address is accepted when its bit is set in a separate group-address hash table. Both tables are 64 bits wide and are indexed by six bits of a CRC-32 that is computed serially as the address bytes arrive. All configuration is latched when a frame starts.

Top module: `addrfilt_top`

## Requirements
- R1: For the all-ones destination, when promiscuous mode is off, the frame is accepted with reason 1 if `bcastReject` is 0. It is rejected with reason 0 if `bcastReject` is 1, whatever the hash tables hold.
- R2: For a unicast destination (LSB of the first byte is 0) that equals `stationAddr`, the frame is accepted with reason 2. `stationAddr[47:40]` is compared with the first byte received.
- R3: For a unicast destination that does not match exactly, the frame is accepted with reason 3 if `uniHash[idx]` is 1. Otherwise it is rejected with reason 0.
- R4: For a destination whose first byte has LSB 1 and that is not all ones, the frame is accepted with reason 4 if `grpHash[idx]` is 1. Otherwise it is rejected with reason 0. The individual table and the station address are not used for such a destination.
- R5: When `promiscOn` is 1, every frame is accepted with reason 5, even a broadcast frame under `bcastReject`.
- R6: `idx` is bits 31:26 of a CRC-32 register (polynomial 0x04C11DB7, preset to all ones, not inverted). The register is updated over the six destination bytes, least significant bit of each byte first.
- R7: `decValid` is high for exactly one cycle. That cycle follows the clock edge that captures the sixth destination byte.
- R8: `reason` is 0 none, 1 broadcast, 2 exact, 3 unicast hash, 4 group hash, 5 promiscuous. `accept` is 1 exactly when `reason` is not 0.
- R9: A `sofIn` that arrives before six bytes have been taken restarts capture. The aborted frame produces no decision.
- R10: All configuration inputs are latched in the `sofIn` cycle. Changes made later in the frame do not affect that frame's decision.
- R11: Cycles with `byteValid` low are skipped. Bytes after the sixth, and bytes with no preceding `sofIn`, produce no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sofIn | input | 1 | Start of frame; the byte in this cycle is byte 0 if `byteValid` is high |
| byteValid | input | 1 | `rxByte` holds a frame byte this cycle |
| rxByte | input | 8 | Received byte |
| stationAddr | input | 48 | Station address, first wire byte in bits 47:40 |
| uniHash | input | 64 | Individual-address hash table, bit n for index n |
| grpHash | input | 64 | Group-address hash table, bit n for index n |
| bcastReject | input | 1 | 1 rejects broadcast frames, 0 accepts them |
| promiscOn | input | 1 | 1 accepts every frame |
| decValid | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Verdict, valid with `decValid` |
| reason | output | 3 | Rule that matched, valid with `decValid` |

## Verification
The assertions assume `sofIn` is a clean strobe and that reset is held long enough to clear capture. They also assume the snapshot of promiscuous and broadcast controls stays fixed from the last address byte until `decValid`, which holds because no start can land between them. The bench drives every input on the falling edge. It raises `sofIn` only on a frame's first byte or on a deliberate restart, and it changes configuration mid-frame only in the test aimed at the latching rule.

// File: rtl/addrfilt_pkg.sv
package addrfilt_pkg;

  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_BCAST   = 3'd1,
    RSN_EXACT   = 3'd2,
    RSN_UHASH   = 3'd3,
    RSN_GHASH   = 3'd4,
    RSN_PROMISC = 3'd5
  } reason_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic start;  // frame start seen this cycle
    logic take;   // rxByte is an address byte this cycle
    logic last;   // rxByte is the final address byte
  } strobe_t;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  // One byte into a left-shifting CRC register, bit 0 of the byte first
  function automatic logic [31:0] crcByte(input logic [31:0] crcIn,
                                          input logic [7:0]  dataIn);
    logic [31:0] c;
    logic        fb;
    c = crcIn;
    for (int k = 0; k < 8; k++) begin
      fb = c[31] ^ dataIn[k];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/addrfilt_ctrl.sv
module addrfilt_ctrl
  import addrfilt_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sofIn,
  input  logic    byteValid,
  output strobe_t strb
);

  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

  logic             active;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strb.start = sofIn;
    strb.take  = byteValid && (active || sofIn);
    strb.last  = byteValid && active && !sofIn && (cnt == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (sofIn) begin
      active <= 1'b1;
      cnt    <= byteValid ? CNT_W'(1) : '0;
    end else if (strb.take) begin
      if (strb.last) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R9: a start always (re)opens capture
  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    sofIn |=> active);

  // R9: byte count never reaches the address length while capturing
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CNT_W'(ADDR_BYTES));

  // R11: with no capture open and no start, nothing advances
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !sofIn) |=> (!active && $stable(cnt)));

endmodule

// File: rtl/addrfilt_dp.sv
module addrfilt_dp
  import addrfilt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [7:0]              rxByte,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic [(1<<HASH_BITS)-1:0] uniHash,
  input  logic [(1<<HASH_BITS)-1:0] grpHash,
  input  logic                    bcastReject,
  input  logic                    promiscOn,
  output logic                    decValid,
  output logic                    accept,
  output reason_e                 reason
);

  localparam int ADDR_W    = 8 * ADDR_BYTES;
  localparam int HASH_SIZE = 1 << HASH_BITS;

  // configuration snapshot
  logic [ADDR_W-1:0]    stationSnap;
  logic [HASH_SIZE-1:0] uniSnap;
  logic [HASH_SIZE-1:0] grpSnap;
  logic                 bcastRejSnap;
  logic                 promSnap;

  // address capture: holds all but the final byte
  logic [ADDR_W-9:0]    addrR;
  logic [31:0]          crcR;
  logic [31:0]          nextCrc;
  logic [ADDR_W-1:0]    fullAddr;
  logic [HASH_BITS-1:0] hashIdx;
  logic                 isBcast;
  logic                 isGroup;
  logic                 isExact;
  reason_e              decRsn;

  always_comb begin
    nextCrc  = crcByte(strb.start ? 32'hFFFF_FFFF : crcR, rxByte);
    fullAddr = {addrR, rxByte};
    hashIdx  = nextCrc[31 -: HASH_BITS];
    isBcast  = &fullAddr;
    isGroup  = fullAddr[ADDR_W-8];
    isExact  = (fullAddr == stationSnap);

    if (promSnap)               decRsn = RSN_PROMISC;
    else if (isBcast)           decRsn = bcastRejSnap ? RSN_NONE : RSN_BCAST;
    else if (isGroup)           decRsn = grpSnap[hashIdx] ? RSN_GHASH : RSN_NONE;
    else if (isExact)           decRsn = RSN_EXACT;
    else if (uniSnap[hashIdx])  decRsn = RSN_UHASH;
    else                        decRsn = RSN_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stationSnap  <= '0;
      uniSnap      <= '0;
      grpSnap      <= '0;
      bcastRejSnap <= 1'b0;
      promSnap     <= 1'b0;
    end else if (strb.start) begin
      stationSnap  <= stationAddr;
      uniSnap      <= uniHash;
      grpSnap      <= grpHash;
      bcastRejSnap <= bcastReject;
      promSnap     <= promiscOn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcR  <= '1;
      addrR <= '0;
    end else if (strb.take) begin
      crcR  <= nextCrc;
      addrR <= {addrR[ADDR_W-17:0], rxByte};
    end else if (strb.start) begin
      crcR  <= '1;
      addrR <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid <= 1'b0;
      accept   <= 1'b0;
      reason   <= RSN_NONE;
    end else begin
      decValid <= strb.last;
      if (strb.last) begin
        accept <= (decRsn != RSN_NONE);
        reason <= decRsn;
      end
    end
  end

  // R7: decision strobe never lasts two cycles
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid);

  // R8: verdict and reason agree
  p_accept_reason_r8: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> (accept == (reason != RSN_NONE)));

  // R5: promiscuous snapshot forces the promiscuous reason
  p_promisc_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && promSnap) |-> (reason == RSN_PROMISC));

  // R1: broadcast reason never appears under a broadcast-reject snapshot
  p_bcast_policy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && bcastRejSnap) |-> (reason != RSN_BCAST));

endmodule

// File: rtl/addrfilt_top.sv
module addrfilt_top
  import addrfilt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sofIn,
  input  logic                      byteValid,
  input  logic [7:0]                rxByte,
  input  logic [8*ADDR_BYTES-1:0]   stationAddr,
  input  logic [(1<<HASH_BITS)-1:0] uniHash,
  input  logic [(1<<HASH_BITS)-1:0] grpHash,
  input  logic                      bcastReject,
  input  logic                      promiscOn,
  output logic                      decValid,
  output logic                      accept,
  output logic [2:0]                reason
);

  strobe_t strb;
  reason_e dpReason;

  addrfilt_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sofIn     (sofIn),
    .byteValid (byteValid),
    .strb      (strb)
  );

  addrfilt_dp #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .rxByte      (rxByte),
    .stationAddr (stationAddr),
    .uniHash     (uniHash),
    .grpHash     (grpHash),
    .bcastReject (bcastReject),
    .promiscOn   (promiscOn),
    .decValid    (decValid),
    .accept      (accept),
    .reason      (dpReason)
  );

  assign reason = dpReason;

endmodule

// File: tb/sim_addrfilt_top.sv
module sim_addrfilt_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sofIn = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic [47:0] stationAddr = 48'h02_11_22_33_44_55;
  logic [63:0] uniHash = '0;
  logic [63:0] grpHash = '0;
  logic        bcastReject = 1'b0;
  logic        promiscOn = 1'b0;
  logic        decValid;
  logic        accept;
  logic [2:0]  reason;

  int checks = 0;
  int errors = 0;
  int pulses = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  addrfilt_top u0 (
    .clk(clk), .rstN(rstN), .sofIn(sofIn), .byteValid(byteValid),
    .rxByte(rxByte), .stationAddr(stationAddr), .uniHash(uniHash),
    .grpHash(grpHash), .bcastReject(bcastReject), .promiscOn(promiscOn),
    .decValid(decValid), .accept(accept), .reason(reason)
  );

  always @(posedge clk) if (rstN && decValid) pulses++;

  typedef struct packed {
    logic [47:0] dst;
    logic        prom;
    logic        brej;
    logic        fill;   // both hash tables all ones when set
    logic        acc;
    logic [2:0]  rsn;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1},  // R1 accept
    '{48'hFFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0},  // R1 reject
    '{48'h0211_2233_4455, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2},  // R2
    '{48'h0211_2233_4456, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},  // R3 miss
    '{48'h0211_2233_4456, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3},  // R3 hit
    '{48'h0100_5E00_0001, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},  // R4 miss
    '{48'h0100_5E00_0001, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4},  // R4 hit
    '{48'h0100_5E00_0001, 1'b1, 1'b0, 1'b0, 1'b1, 3'd5},  // R5
    '{48'hFFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b1, 3'd5},  // R5 over R1
    '{48'h0211_2233_4455, 1'b1, 1'b0, 1'b0, 1'b1, 3'd5}   // R5 over R2
  };

  task automatic check(input logic cond, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reflected-form CRC; the top six bits of the normal form are the
  // low six bits of the reflected register, reversed.
  function automatic logic [5:0] refIdx(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = a[47-8*i -: 8];
      for (int k = 0; k < 8; k++)
        r = (r[0] ^ b[k]) ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  // Drive one byte on the falling edge
  task automatic putByte(input logic sof, input logic [7:0] b);
    @(negedge clk);
    sofIn = sof; byteValid = 1'b1; rxByte = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sofIn = 1'b0; byteValid = 1'b0;
    end
  endtask

  // Send six address bytes, optional idle gap between them; then check
  // the strobe one cycle after the last byte and its drop the cycle after.
  task automatic frame(input logic [47:0] dst, input int gap,
                       input logic expAcc, input logic [2:0] expRsn,
                       input string req);
    for (int i = 0; i < 6; i++) begin
      putByte(i == 0, dst[47-8*i -: 8]);
      if (i == 5) check(decValid == 1'b0, "R7 early", decValid, 0);
      if (i < 5 && gap > 0) idle(gap);
    end
    idle(1);
    check(decValid == 1'b1, {req, " R7 valid"}, decValid, 1);
    check(accept == expAcc, {req, " accept"}, accept, expAcc);
    check(reason == expRsn, {req, " R8 reason"}, reason, expRsn);
    idle(1);
    check(decValid == 1'b0, "R7 one cycle", decValid, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] ua;
    logic [47:0] ga;
    logic [5:0]  ix;
    int p0;

    repeat (4) @(negedge clk);
    check(decValid == 1'b0 && accept == 1'b0 && reason == 3'd0,
          "R7 reset state", {decValid, accept, reason}, 0);
    rstN = 1'b1;
    idle(2);

    // vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      promiscOn = VECS[v].prom; bcastReject = VECS[v].brej;
      uniHash = {64{VECS[v].fill}}; grpHash = {64{VECS[v].fill}};
      frame(VECS[v].dst, (v % 3), VECS[v].acc, VECS[v].rsn, "table");
    end
    @(negedge clk);
    promiscOn = 0; bcastReject = 0; uniHash = '0; grpHash = '0;

    // R6/R3: single-bit individual table at the computed index
    ua = 48'h0211_2233_4457;
    ix = refIdx(ua);
    uniHash = 64'd1 << ix;
    frame(ua, 0, 1'b1, 3'd3, "R6 R3 bit set");
    uniHash = ~(64'd1 << ix);
    frame(ua, 0, 1'b0, 3'd0, "R6 R3 bit clear");
    uniHash = '0;

    // R6/R4: single-bit group table; individual table full must not help
    ga = 48'h0300_0000_0042;
    ix = refIdx(ga);
    grpHash = 64'd1 << ix;
    frame(ga, 1, 1'b1, 3'd4, "R6 R4 bit set");
    grpHash = ~(64'd1 << ix); uniHash = '1;
    frame(ga, 0, 1'b0, 3'd0, "R6 R4 bit clear");
    uniHash = '0; grpHash = '0;

    // R9: restart after three bytes, exactly one decision
    p0 = pulses;
    putByte(1'b1, 8'hFF); putByte(1'b0, 8'hFF); putByte(1'b0, 8'hFF);
    frame(48'h0211_2233_4455, 0, 1'b1, 3'd2, "R9 restart");
    check(pulses - p0 == 1, "R9 pulse count", pulses - p0, 1);

    // R10: promiscuous raised and station changed mid-frame
    ua = 48'h0211_2233_4499;
    putByte(1'b1, ua[47:40]); putByte(1'b0, ua[39:32]);
    promiscOn = 1'b1; stationAddr = ua;
    for (int i = 2; i < 6; i++) putByte(1'b0, ua[47-8*i -: 8]);
    idle(1);
    check(decValid == 1'b1 && reason == 3'd0, "R10 mid-frame change",
          reason, 0);
    promiscOn = 1'b0; stationAddr = 48'h02_11_22_33_44_55;
    idle(1);

    // R11: extra payload bytes and bytes with no start give no decision
    p0 = pulses;
    frame(48'h0211_2233_4455, 2, 1'b1, 3'd2, "R11 gaps");
    for (int i = 0; i < 12; i++) putByte(1'b0, 8'hA5);
    idle(2);
    check(pulses - p0 == 1, "R11 payload ignored", pulses - p0, 1);
    p0 = pulses;
    for (int i = 0; i < 8; i++) putByte(1'b0, 8'hFF);
    idle(2);
    check(pulses - p0 == 0, "R11 no start", pulses - p0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule